// File: doc/BRIEF.md
# Four-Level Prioritized Interrupt Controller

This block chooses which of ten interrupt requests a processor core should service next. Every source has its own enable bit, and a global enable gates all of them. Each source also has a two-bit priority, which gives four levels. The block tracks which levels already have a handler running. It offers a new request only when that request sits at a level strictly above every level in service. Among the pending sources at the winning level, a fixed polling order decides.

The chosen request leaves on a valid/ready pair together with its 16-bit vector address. The offer is live: it is worked out again every cycle from the current requests and the in-service state. Until the core takes it, the vector may change or the valid may drop, for example when a level-sensitive input returns high. A transfer happens on any clock edge where `irq_valid` and `irq_ready` are both high. At that edge the block records the winning level as in service, clears the source's edge flag if it has one, and one cycle later pulses that source's acknowledge bit. A return strobe ends the highest level in service.

Four external inputs are active low. Each can be set to falling-edge mode, where an event is latched, or to low-level mode, where nothing is latched. The serial source also carries a SPI request, which counts only when its own enable bit is set. Configuration is written through a small select/data write port.

Top module: `pic4_ctl`

## Requirements
- R1: After reset, `irq_valid` and `src_ack` are 0. All enables, priorities and trigger types are 0, and no level is in service.
- R2: A source can make `irq_valid` high only when its enable bit and the global enable are both 1. The write port has `cfg_sel`=0 for enables: `cfg_wdata[9:0]` are the source enables by source index, bit 10 is the SPI enable and bit 11 is the global enable.
- R3: A source's level is {high bit, low bit}. The low bits are written with `cfg_sel`=1 and the high bits with `cfg_sel`=2, each at `cfg_wdata[9:0]` by source index. The pending source with the highest level wins, whatever its polling position.
- R4: Within one level, the lowest source index wins. The source indices, in polling order, are: 0 external 0, 1 brown-out, 2 timer 0, 3 external 1, 4 timer 1, 5 counter array, 6 external 2, 7 external 3, 8 serial/SPI, 9 timer 2.
- R5: `irq_vector` is 0003h for external 0, 004Bh for brown-out, 000Bh for timer 0, 0013h for external 1, 001Bh for timer 1, 0033h for counter array, 003Bh for external 2, 0043h for external 3, 0023h for serial/SPI and 002Bh for timer 2.
- R6: One cycle after a transfer edge, `src_ack` carries a single pulse on the bit of the granted source index. At every other time it is 0.
- R7: A request is offered only when its level is strictly above every level in service. Each transfer adds its level to the in-service set. `ret_strobe` removes the highest level in service.
- R8: The trigger types are written with `cfg_sel`=3, `cfg_wdata[3:0]` for external 0 to 3. When an input's type bit is 1, a falling edge on it sets a request flag. That flag stays set after the pin rises and is cleared by the transfer that grants the input.
- R9: When an input's type bit is 0, the input requests while it is low and stops requesting once it is high again, with nothing latched.
- R10: The SPI request reaches the serial source only when the SPI enable bit is 1, and it is still subject to the serial source enable (bit 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n | input | 4 | External interrupt pins 0 to 3, active low, asynchronous |
| bo_req | input | 1 | Brown-out request |
| t0_req | input | 1 | Timer 0 request |
| t1_req | input | 1 | Timer 1 request |
| pca_req | input | 1 | Counter array request |
| ser_req | input | 1 | Serial port request |
| spi_req | input | 1 | SPI request, merged into the serial source |
| t2_req | input | 1 | Timer 2 request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 12 | Configuration write data |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | Core takes the offered request |
| irq_vector | output | 16 | Vector address of the offered request |
| ret_strobe | input | 1 | Return from the current handler |
| src_ack | output | 10 | One-hot acknowledge by source index |

## Verification
The bench builds the block with its default parameters: two synchronizer stages on the external pins and ten sources in four levels. With two stages, a low pulse on a pin that lasts a single clock period and spans one rising edge is enough to set an edge flag. That makes the latching in edge mode observable after the pin has returned high. The four-level setting brings a two-deep preemption, one level 3 handler over a level 1 handler, within reach. This lets the bench check that an equal-level request stays blocked, and that it is released only by the second return strobe.

// File: rtl/pic4_pkg.sv
package pic4_pkg;
  localparam int NSRC = 10;
  localparam int NLVL = 4;
  localparam int LVLW = $clog2(NLVL);
  localparam int IDXW = $clog2(NSRC);
  localparam int VECW = 16;
  localparam int NEXT = 4;
  localparam int CFGW = NSRC + 2;   // source enables, SPI enable, global enable

  typedef enum logic [IDXW-1:0] {
    SRC_X0  = 4'd0,
    SRC_BO  = 4'd1,
    SRC_T0  = 4'd2,
    SRC_X1  = 4'd3,
    SRC_T1  = 4'd4,
    SRC_CA  = 4'd5,
    SRC_X2  = 4'd6,
    SRC_X3  = 4'd7,
    SRC_SER = 4'd8,
    SRC_T2  = 4'd9
  } src_e;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_PLO  = 2'd1,
    SEL_PHI  = 2'd2,
    SEL_TYPE = 2'd3
  } cfg_sel_e;

  // vector address for a source index (polling position)
  function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
    logic [VECW-1:0] v;
    case (idx)
      SRC_X0:  v = 16'h0003;
      SRC_BO:  v = 16'h004B;
      SRC_T0:  v = 16'h000B;
      SRC_X1:  v = 16'h0013;
      SRC_T1:  v = 16'h001B;
      SRC_CA:  v = 16'h0033;
      SRC_X2:  v = 16'h003B;
      SRC_X3:  v = 16'h0043;
      SRC_SER: v = 16'h0023;
      SRC_T2:  v = 16'h002B;
      default: v = 16'h0003;
    endcase
    return v;
  endfunction

  // polling slot of external pin k
  function automatic int ext_slot(input int k);
    int s;
    case (k)
      0:       s = 0;
      1:       s = 3;
      2:       s = 6;
      default: s = 7;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pic4_ext_trig.sv
module pic4_ext_trig #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC-1:0] sh;
  logic            prev;
  logic            flag;
  logic            pin_s;
  logic            fall;

  assign pin_s = sh[SYNC-1];
  assign fall  = prev & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      prev <= 1'b1;
      flag <= 1'b0;
    end else begin
      sh   <= (sh << 1) | SYNC'(pin_n);
      prev <= pin_s;
      if (!edge_mode)
        flag <= 1'b0;
      else if (fall)
        flag <= 1'b1;          // a fresh event beats a same-cycle clear
      else if (clr)
        flag <= 1'b0;
    end
  end

  assign req = edge_mode ? flag : ~pin_s;
endmodule

// File: rtl/pic4_arb.sv
module pic4_arb
  import pic4_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] plo,
  input  logic [NSRC-1:0] phi,
  input  logic [NLVL-1:0] active,
  output logic            win_valid,
  output logic [IDXW-1:0] win_idx,
  output logic [LVLW-1:0] win_lvl
);
  logic [NLVL-1:0][NSRC-1:0] by_lvl;

  always_comb begin
    for (int l = 0; l < NLVL; l++)
      for (int s = 0; s < NSRC; s++)
        by_lvl[l][s] = pend[s] && ({phi[s], plo[s]} == LVLW'(l));
  end

  always_comb begin
    logic blocked;
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      blocked = |(active >> l);
      if (!win_valid && !blocked && |by_lvl[l]) begin
        win_valid = 1'b1;
        win_lvl   = LVLW'(l);
        for (int s = NSRC - 1; s >= 0; s--)
          if (by_lvl[l][s]) win_idx = IDXW'(s);
      end
    end
  end
endmodule

// File: rtl/pic4_isr.sv
module pic4_isr
  import pic4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [LVLW-1:0] take_lvl,
  input  logic            ret,
  output logic [NLVL-1:0] active
);
  logic [NLVL-1:0] nxt;

  always_comb begin
    logic [LVLW-1:0] top;
    top = '0;
    for (int l = 0; l < NLVL; l++)
      if (active[l]) top = LVLW'(l);
    nxt = active;
    if (ret && |active) nxt[top] = 1'b0;
    if (take) nxt[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= '0;
    else        active <= nxt;
  end
endmodule

// File: rtl/pic4_ctl.sv
module pic4_ctl
  import pic4_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEXT-1:0]      ext_n,
  input  logic                 bo_req,
  input  logic                 t0_req,
  input  logic                 t1_req,
  input  logic                 pca_req,
  input  logic                 ser_req,
  input  logic                 spi_req,
  input  logic                 t2_req,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [CFGW-1:0]      cfg_wdata,
  output logic                 irq_valid,
  input  logic                 irq_ready,
  output logic [VECW-1:0]      irq_vector,
  input  logic                 ret_strobe,
  output logic [NSRC-1:0]      src_ack
);
  localparam int SPI_BIT  = NSRC;
  localparam int GLOB_BIT = NSRC + 1;

  logic [NSRC-1:0] src_en;
  logic            spi_en;
  logic            glob_en;
  logic [NSRC-1:0] plo;
  logic [NSRC-1:0] phi;
  logic [NEXT-1:0] etype;

  logic [NEXT-1:0] ext_req;
  logic [NEXT-1:0] ext_clr;
  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] pend;
  logic [NLVL-1:0] in_svc;
  logic            win_valid;
  logic [IDXW-1:0] win_idx;
  logic [LVLW-1:0] win_lvl;
  logic            take;

  // configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en  <= '0;
      spi_en  <= 1'b0;
      glob_en <= 1'b0;
      plo     <= '0;
      phi     <= '0;
      etype   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_EN: begin
          src_en  <= cfg_wdata[NSRC-1:0];
          spi_en  <= cfg_wdata[SPI_BIT];
          glob_en <= cfg_wdata[GLOB_BIT];
        end
        SEL_PLO:  plo   <= cfg_wdata[NSRC-1:0];
        SEL_PHI:  phi   <= cfg_wdata[NSRC-1:0];
        SEL_TYPE: etype <= cfg_wdata[NEXT-1:0];
        default:  ;
      endcase
    end
  end

  assign take = irq_valid && irq_ready;

  // external pin front ends
  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    assign ext_clr[k] = take && (win_idx == IDXW'(ext_slot(k)));
    pic4_ext_trig #(.SYNC(SYNC_STAGES)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_n[k]),
      .edge_mode (etype[k]),
      .clr       (ext_clr[k]),
      .req       (ext_req[k])
    );
  end

  always_comb begin
    raw          = '0;
    for (int k = 0; k < NEXT; k++)
      raw[ext_slot(k)] = ext_req[k];
    raw[SRC_BO]  = bo_req;
    raw[SRC_T0]  = t0_req;
    raw[SRC_T1]  = t1_req;
    raw[SRC_CA]  = pca_req;
    raw[SRC_SER] = ser_req | (spi_req & spi_en);
    raw[SRC_T2]  = t2_req;
  end

  assign pend = raw & src_en & {NSRC{glob_en}};

  pic4_arb u_arb (
    .pend      (pend),
    .plo       (plo),
    .phi       (phi),
    .active    (in_svc),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  pic4_isr u_isr (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_lvl (win_lvl),
    .ret      (ret_strobe),
    .active   (in_svc)
  );

  assign irq_valid  = win_valid;
  assign irq_vector = vec_of(win_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    src_ack <= '0;
    else if (take) src_ack <= NSRC'(1) << win_idx;
    else           src_ack <= '0;
  end
endmodule

// File: rtl/pic4_chk.sv
module pic4_chk
  import pic4_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            irq_valid,
  input logic            irq_ready,
  input logic [VECW-1:0] irq_vector,
  input logic            ret_strobe,
  input logic [NSRC-1:0] src_ack,
  input logic            glob,
  input logic [NLVL-1:0] active
);
  logic hs;
  assign hs = irq_valid && irq_ready;

  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack));

  assert_ack_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> $onehot(src_ack));

  assert_no_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> (src_ack == '0));

  assert_vector_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector[2:0] == 3'b011 && irq_vector[VECW-1:7] == '0));

  assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !glob |-> !irq_valid);

  assert_push_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !ret_strobe) |=> ($countones(active) == $past($countones(active)) + 1));

  assert_pop_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !hs && active != '0) |=>
      ($countones(active) + 1 == $past($countones(active))));
endmodule

bind pic4_ctl pic4_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_vector (irq_vector),
  .ret_strobe (ret_strobe),
  .src_ack    (src_ack),
  .glob       (glob_en),
  .active     (in_svc)
);

// File: tb/pic4_ctl_bench.sv
module pic4_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ext_n = 4'hF;
  logic        bo_req = 0, t0_req = 0, t1_req = 0, pca_req = 0;
  logic        ser_req = 0, spi_req = 0, t2_req = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [11:0] cfg_wdata = 0;
  logic        irq_valid;
  logic        irq_ready = 0;
  logic [15:0] irq_vector;
  logic        ret_strobe = 0;
  logic [9:0]  src_ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pic4_ctl u_pic4_ctl (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n),
    .bo_req(bo_req), .t0_req(t0_req), .t1_req(t1_req), .pca_req(pca_req),
    .ser_req(ser_req), .spi_req(spi_req), .t2_req(t2_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
    .ret_strobe(ret_strobe), .src_ack(src_ack)
  );

  localparam logic [11:0] GLOB = 12'h800;
  localparam logic [11:0] SPIE = 12'h400;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    ext_n = 4'hF; bo_req = 0; t0_req = 0; t1_req = 0; pca_req = 0;
    ser_req = 0; spi_req = 0; t2_req = 0; irq_ready = 0; ret_strobe = 0; cfg_we = 0;
    @(negedge clk); rst_n = 0;
    idle(2); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] s, input logic [11:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic take_it();
    irq_ready = 1;
    @(negedge clk);
    irq_ready = 0;
  endtask

  task automatic ret_it();
    ret_strobe = 1;
    @(negedge clk);
    ret_strobe = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 valid after reset", irq_valid, 0);
    chk("R1 ack after reset", src_ack, 0);
    t0_req = 1; idle(1);
    chk("R1 enables clear at reset", irq_valid, 0);
  endtask

  task automatic t_gate();
    do_reset();
    t0_req = 1;
    cfg(2'd0, 12'h004);
    chk("R2 global enable off blocks", irq_valid, 0);
    cfg(2'd0, GLOB | 12'h010);
    chk("R2 source enable off blocks", irq_valid, 0);
    cfg(2'd0, GLOB | 12'h004);
    chk("R2 both enables on", irq_valid, 1);
    chk("R2 vector timer0", irq_vector, 16'h000B);
  endtask

  task automatic t_vectors();
    logic [15:0] exp_ext[4];
    exp_ext[0] = 16'h0003; exp_ext[1] = 16'h0013;
    exp_ext[2] = 16'h003B; exp_ext[3] = 16'h0043;
    do_reset();
    cfg(2'd0, GLOB | 12'h3FF);
    bo_req = 1; idle(1);  chk("R5 brown-out vector", irq_vector, 16'h004B); bo_req = 0;
    t0_req = 1; idle(1);  chk("R5 timer0 vector", irq_vector, 16'h000B); t0_req = 0;
    t1_req = 1; idle(1);  chk("R5 timer1 vector", irq_vector, 16'h001B); t1_req = 0;
    pca_req = 1; idle(1); chk("R5 counter array vector", irq_vector, 16'h0033); pca_req = 0;
    ser_req = 1; idle(1); chk("R5 serial vector", irq_vector, 16'h0023); ser_req = 0;
    t2_req = 1; idle(1);  chk("R5 timer2 vector", irq_vector, 16'h002B); t2_req = 0;
    for (int k = 0; k < 4; k++) begin
      ext_n[k] = 0; idle(4);
      chk("R5 external vector", irq_vector, {16'h0, exp_ext[k]});
      ext_n[k] = 1; idle(4);
    end
  endtask

  task automatic t_order();
    do_reset();
    cfg(2'd0, GLOB | 12'h236);
    t1_req = 1; pca_req = 1; t2_req = 1; idle(1);
    chk("R4 timer1 ahead of counter array", irq_vector, 16'h001B);
    t1_req = 0; idle(1);
    chk("R4 counter array ahead of timer2", irq_vector, 16'h0033);
    bo_req = 1; t0_req = 1; idle(1);
    chk("R4 brown-out ahead of timer0", irq_vector, 16'h004B);
  endtask

  task automatic t_levels();
    do_reset();
    cfg(2'd0, GLOB | 12'h204);
    cfg(2'd1, 12'h004);
    cfg(2'd2, 12'h200);
    t0_req = 1; t2_req = 1; idle(1);
    chk("R3 level2 timer2 beats level1 timer0", irq_vector, 16'h002B);
    cfg(2'd2, 12'h204);
    chk("R3 level3 timer0 beats level2", irq_vector, 16'h000B);
  endtask

  task automatic t_preempt();
    do_reset();
    cfg(2'd0, GLOB | 12'h214);
    cfg(2'd1, 12'h214);
    cfg(2'd2, 12'h200);
    t1_req = 1; idle(1);
    chk("R6 offer timer1", irq_vector, 16'h001B);
    take_it();
    chk("R6 ack timer1 bit", src_ack, 10'h010);
    idle(1);
    chk("R6 ack single cycle", src_ack, 0);
    chk("R7 same level blocked", irq_valid, 0);
    t0_req = 1; idle(1);
    chk("R7 equal level no preempt", irq_valid, 0);
    t2_req = 1; idle(1);
    chk("R7 higher level preempts", irq_vector, 16'h002B);
    take_it();
    chk("R6 ack timer2 bit", src_ack, 10'h200);
    t2_req = 0; idle(1);
    chk("R7 nothing above level3", irq_valid, 0);
    ret_it();
    chk("R7 level1 still in service", irq_valid, 0);
    ret_it();
    chk("R7 released after second return", irq_valid, 1);
    chk("R7 timer0 next by polling", irq_vector, 16'h000B);
  endtask

  task automatic t_edge();
    do_reset();
    cfg(2'd3, 12'h001);
    cfg(2'd0, GLOB | 12'h001);
    ext_n[0] = 0; idle(1); ext_n[0] = 1;
    idle(5);
    chk("R8 falling edge latched", irq_valid, 1);
    chk("R8 external0 vector", irq_vector, 16'h0003);
    take_it();
    chk("R8 ack external0", src_ack, 10'h001);
    ret_it();
    idle(1);
    chk("R8 flag cleared by grant", irq_valid, 0);
  endtask

  task automatic t_level_mode();
    do_reset();
    cfg(2'd0, GLOB | 12'h008);
    ext_n[1] = 0; idle(4);
    chk("R9 low input requests", irq_vector, 16'h0013);
    chk("R9 low input valid", irq_valid, 1);
    ext_n[1] = 1; idle(4);
    chk("R9 request drops when high", irq_valid, 0);
  endtask

  task automatic t_spi();
    do_reset();
    spi_req = 1;
    cfg(2'd0, GLOB | 12'h100);
    chk("R10 spi enable off", irq_valid, 0);
    cfg(2'd0, GLOB | SPIE | 12'h100);
    chk("R10 spi reaches serial vector", irq_vector, 16'h0023);
    chk("R10 spi valid", irq_valid, 1);
    cfg(2'd0, GLOB | SPIE);
    chk("R10 serial enable still needed", irq_valid, 0);
  endtask

  initial begin
    t_reset();
    t_gate();
    t_vectors();
    t_order();
    t_levels();
    t_preempt();
    t_edge();
    t_level_mode();
    t_spi();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule